// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block lets an internal requester reach up to four slave peripherals over a narrow external bus. Address and data share one 16-bit bidirectional bus, and each peripheral has its own active-low chip select. The requester presents one transfer at a time. A transfer carries a 32-bit address, 16-bit write data, two byte enables and a direction flag. When the transfer ends, the block returns read data, a one-cycle done pulse and an error flag.

Bits 31:20 of the address pick a 1 Mbyte region, and each chip select owns one fixed region. Only address bits 15:0 reach the slave, so each slave sees 64 Kbytes. A transfer has three parts. First comes an address phase, strobed by an address latch enable. Then comes a data phase that lasts until the slave pulls its ready line low. Last comes a turnaround cycle with every chip select released. The ready line is pulled up on the board, so a slave that never answers ends the transfer through a bus-clock timeout.

Top module: `mux_bus_master`

## Requirements
- R1: While reset is held, all chip selects are high, ale is low, oe_n is high, both we_n bits are high, and done and err are low.
- R2: An accepted mapped transfer begins with exactly one cycle in which ale is high, the selected chip select is low, ad carries addr[15:0], and wr_nrd is 1 for a write and 0 for a read.
- R3: cs_n[i] is used when addr[31:20] equals CS_BASE+i (CS_BASE defaults to 4, so regions 0x004 to 0x007). Any other region ends the transfer with done and err both high in the next cycle, with no chip select and no ale.
- R4: In the data phase of a write, ad carries the write data in little-endian lane order (bits 7:0 hold the byte at the even address). we_n[0] is low exactly when be[0] is 1, and we_n[1] is low exactly when be[1] is 1.
- R5: In the data phase of a read, the block stops driving ad, and oe_n stays low until ready is sampled low. rdata takes the value on ad at that same clock edge.
- R6: A mapped transfer ends only at a clock edge where rdy_n is sampled low. done goes high in the following cycle with err low. A slave that answers in its first data cycle gives done three clocks after the request edge.
- R7: If rdy_n stays high for TIMEOUT data-phase cycles (default 256), the chip select is released and done goes high with err = 1 and rdata = 0.
- R8: Between two transfers there is at least one cycle with all chip selects high. A req that arrives while a transfer is in progress, or in that turnaround cycle, is ignored.
- R9: done is a single-cycle pulse, and err is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle transfer request, taken only when idle |
| addr | input | 32 | Byte address of the transfer |
| we | input | 1 | 1 for a write, 0 for a read |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte-lane enables, bit 0 for the low lane |
| rdata | output | 16 | Read data, valid with done |
| done | output | 1 | Transfer-complete pulse |
| err | output | 1 | Timeout or unmapped address, valid with done |
| cs_n | output | 4 | Active-low slave selects |
| ale | output | 1 | Address latch enable |
| wr_nrd | output | 1 | Direction to the slave, 1 for a write |
| ad | inout | 16 | Multiplexed address/data bus |
| oe_n | output | 1 | Active-low read output enable |
| we_n | output | 2 | Active-low byte-lane write strobes |
| rdy_n | input | 1 | Active-low ready, pulled up externally |

## Verification
The properties assume that rdy_n is high whenever no chip select is low, as the pull-up guarantees. They also assume that a slave drives ad only while oe_n is low. The bench slave model follows both rules, because it asserts ready and drives read data only inside a data phase of its own select. The requester in the bench pulses req for one cycle and holds addr, we, wdata and be steady until it has taken that request. It sends a deliberate second req only in the one test that checks requests made during a transfer are ignored.

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
  parameter int AW       = 32,
  parameter int NCS      = 4,
  parameter int REGION_W = 20,
  parameter int CS_BASE  = 4,
  parameter int DW       = 16,
  parameter int TIMEOUT  = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  input  logic [1:0]      be,
  output logic [DW-1:0]   rdata,
  output logic            done,
  output logic            err,
  output logic [NCS-1:0]  cs_n,
  output logic            ale,
  output logic            wr_nrd,
  inout  wire  [DW-1:0]   ad,
  output logic            oe_n,
  output logic [1:0]      we_n,
  input  logic            rdy_n
);
  localparam int RW   = AW - REGION_W;
  localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int TW   = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_GAP} st_t;
  st_t st;

  logic [SELW-1:0] sel_q;
  logic [DW-1:0]   addr_q, wdata_q;
  logic [1:0]      be_q;
  logic            we_q;
  logic [TW-1:0]   cnt;

  logic [RW-1:0] region, offs;
  logic          hit;
  assign region = addr[AW-1:REGION_W];
  assign offs   = region - RW'(CS_BASE);
  assign hit    = (region >= RW'(CS_BASE)) && (region < RW'(CS_BASE + NCS));

  logic active, ad_oe;
  assign active = (st == S_ADDR) || (st == S_DATA);
  assign ale    = (st == S_ADDR);
  assign cs_n   = active ? ~(NCS'(1) << sel_q) : '1;
  assign wr_nrd = active & we_q;
  assign ad_oe  = ale || (st == S_DATA && we_q);
  assign ad     = ad_oe ? (ale ? addr_q : wdata_q) : 'z;
  assign oe_n   = !(st == S_DATA && !we_q);
  assign we_n   = (st == S_DATA && we_q) ? ~be_q : 2'b11;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      we_q    <= 1'b0;
      cnt     <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          if (hit) begin
            st      <= S_ADDR;
            sel_q   <= offs[SELW-1:0];
            addr_q  <= addr[DW-1:0];
            wdata_q <= wdata;
            be_q    <= be;
            we_q    <= we;
          end else begin
            done  <= 1'b1;
            err   <= 1'b1;
            rdata <= '0;
          end
        end
        S_ADDR: begin
          st  <= S_DATA;
          cnt <= '0;
        end
        S_DATA: begin
          if (!rdy_n) begin
            st    <= S_GAP;
            done  <= 1'b1;
            rdata <= we_q ? '0 : ad;
          end else if (cnt == TW'(TIMEOUT - 1)) begin
            st    <= S_GAP;
            done  <= 1'b1;
            err   <= 1'b1;
            rdata <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module mux_bus_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cs_n,
  input logic           ale,
  input logic           oe_n,
  input logic [1:0]     we_n,
  input logic           wr_nrd,
  input logic           rdy_n,
  input logic           done,
  input logic           err,
  input logic           ad_oe
);
  a_r2_ale_has_select: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ($countones(~cs_n) == 1));
  a_r4_strobe_in_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n != 2'b11) |-> (wr_nrd && !ale && cs_n != '1));
  a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ad_oe);
  a_r6_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && $past(rst_n)) |-> ($past(rdy_n) == 1'b0));
  a_r8_gap_before_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> ($past(cs_n) == '1));
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mux_bus_master mux_bus_master_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .oe_n(oe_n),
  .we_n(we_n), .wr_nrd(wr_nrd), .rdy_n(rdy_n), .done(done), .err(err),
  .ad_oe(ad_oe)
);

// File: tb/mux_bus_master_tb.sv
module mux_bus_master_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req, we;
  logic [31:0] addr;
  logic [15:0] wdata, rdata;
  logic [1:0]  be, we_n;
  logic        done, err, ale, wr_nrd, oe_n, rdy_n;
  logic [3:0]  cs_n;
  wire  [15:0] ad;

  mux_bus_master u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we(we), .wdata(wdata),
    .be(be), .rdata(rdata), .done(done), .err(err), .cs_n(cs_n), .ale(ale),
    .wr_nrd(wr_nrd), .ad(ad), .oe_n(oe_n), .we_n(we_n), .rdy_n(rdy_n)
  );

  int tests = 0, fails = 0;

  logic [15:0] smem [4][16];
  logic [15:0] lat_addr;
  logic [1:0]  lat_cs;
  logic [7:0]  scnt, swait;
  logic        snever;
  int          ale_cnt = 0;
  logic [1:0]  cs_idx;
  logic        cs_act;

  assign cs_act = (cs_n != 4'hF);
  always_comb begin
    cs_idx = 2'd0;
    for (int i = 0; i < 4; i++) if (!cs_n[i]) cs_idx = 2'(i);
  end
  assign rdy_n = !(cs_act && !ale && scnt == swait && !snever);
  assign ad    = (!oe_n && cs_act) ? smem[lat_cs][lat_addr[4:1]] : 16'bz;

  initial begin
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 16; w++) smem[c][w] = 16'h0000;
    scnt = 8'd0; lat_addr = 16'd0; lat_cs = 2'd0;
  end

  always @(posedge clk) begin
    if (ale) begin
      lat_addr <= ad;
      lat_cs   <= cs_idx;
      scnt     <= 8'd0;
      ale_cnt  <= ale_cnt + 1;
    end else if (cs_act) begin
      scnt <= scnt + 8'd1;
      if (!rdy_n && wr_nrd) begin
        if (!we_n[0]) smem[lat_cs][lat_addr[4:1]][7:0]  <= ad[7:0];
        if (!we_n[1]) smem[lat_cs][lat_addr[4:1]][15:8] <= ad[15:8];
      end
    end
  end

  int gap_viol = 0, dcyc = 0;
  logic prev_act = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ale && prev_act) gap_viol++;
      if (cs_act && !ale) dcyc++;
    end
    prev_act = cs_act;
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  logic [15:0] got_rd;
  logic        got_err;
  int          lat_cyc;

  task automatic txn(input logic w, input logic [31:0] a, input logic [15:0] d,
                     input logic [1:0] b, input logic [7:0] wt, input logic nv);
    swait = wt; snever = nv; dcyc = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0;
    lat_cyc = 1;
    for (int k = 0; k < 2000; k++) begin
      if (done) break;
      @(negedge clk);
      lat_cyc++;
    end
    got_rd = rdata; got_err = err;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [15:0] d;
    logic [1:0]  b;
    logic [7:0]  wt;
    logic [15:0] exp;
    logic        eerr;
    logic [1:0]  ecs;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0040_0002, 16'hBEEF, 2'b11, 8'd0, 16'h0000, 1'b0, 2'd0},
    '{1'b0, 32'h0040_0002, 16'h0000, 2'b11, 8'd2, 16'hBEEF, 1'b0, 2'd0},
    '{1'b1, 32'h0050_0002, 16'h1234, 2'b01, 8'd1, 16'h0000, 1'b0, 2'd1},
    '{1'b0, 32'h0050_0002, 16'h0000, 2'b11, 8'd0, 16'h0034, 1'b0, 2'd1},
    '{1'b1, 32'h0050_0002, 16'hAB00, 2'b10, 8'd0, 16'h0000, 1'b0, 2'd1},
    '{1'b0, 32'h0050_0002, 16'h0000, 2'b11, 8'd3, 16'hAB34, 1'b0, 2'd1},
    '{1'b1, 32'h007F_FFFE, 16'h5A5A, 2'b11, 8'd1, 16'h0000, 1'b0, 2'd3},
    '{1'b0, 32'h007F_FFFE, 16'h0000, 2'b11, 8'd0, 16'h5A5A, 1'b0, 2'd3},
    '{1'b0, 32'h0060_0004, 16'h0000, 2'b11, 8'd1, 16'h0000, 1'b0, 2'd2},
    '{1'b0, 32'h0080_0000, 16'h0000, 2'b11, 8'd0, 16'h0000, 1'b1, 2'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; be = '0;
    swait = 8'd0; snever = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {cs_n, ale, oe_n, we_n, done, err},
          {4'hF, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int ale_before;
      ale_before = ale_cnt;
      txn(VEC[v].w, VEC[v].a, VEC[v].d, VEC[v].b, VEC[v].wt, 1'b0);
      check("R6/R5/R4 result data", 32'(got_rd), 32'(VEC[v].exp));
      check("R3/R9 error flag", 32'(got_err), 32'(VEC[v].eerr));
      if (!VEC[v].eerr) begin
        check("R2 latched address", 32'(lat_addr), 32'(VEC[v].a[15:0]));
        check("R3 chip select", 32'(lat_cs), 32'(VEC[v].ecs));
        check("R6 done latency", 32'(lat_cyc), 32'(3 + VEC[v].wt));
      end else begin
        check("R3 no address phase", 32'(ale_cnt - ale_before), 32'd0);
      end
    end
    check("R4 low lane only", 32'(smem[1][1]), 32'h0000AB34);

    txn(1'b0, 32'h0070_0006, 16'h0, 2'b11, 8'd0, 1'b1);
    check("R7 timeout err", 32'(got_err), 32'd1);
    check("R7 timeout rdata zero", 32'(got_rd), 32'd0);
    check("R7 data cycles", 32'(dcyc), 32'd256);
    check("R7 select released", 32'(cs_n), 32'hF);

    begin
      int ale_before;
      ale_before = ale_cnt;
      swait = 8'd10; snever = 1'b0;
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = 32'h0040_0002; be = 2'b11;
      @(negedge clk);
      req = 1'b0;
      repeat (3) @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 32'h0070_0008; wdata = 16'h7777;
      @(negedge clk);
      req = 1'b0;
      for (int k = 0; k < 50; k++) begin
        if (done) break;
        @(negedge clk);
      end
      check("R8 first read data", 32'(rdata), 32'h0000BEEF);
      req = 1'b1; addr = 32'h0060_0000;
      @(negedge clk);
      req = 1'b0;
      repeat (15) @(negedge clk);
      check("R8 requests ignored", 32'(ale_cnt - ale_before), 32'd1);
      check("R8 ignored write absent", 32'(smem[3][4]), 32'd0);
    end

    txn(1'b1, 32'h0060_0000, 16'h4455, 2'b11, 8'd0, 1'b0);
    txn(1'b0, 32'h0060_0000, 16'h0, 2'b11, 8'd0, 1'b0);
    check("R5 back-to-back read", 32'(got_rd), 32'h00004455);
    check("R8 idle gap kept", 32'(gap_viol), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule